// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Corrector

This block compares the three-byte Hamming check code kept in a NAND page's spare area with the three-byte code recomputed over one 256- or 512-byte data chunk. Each of the three syndrome bytes is the XOR of a stored byte and the matching recomputed byte. From this 24-bit syndrome the block decides whether the chunk is clean, holds a single flipped data bit that can be repaired, holds a flipped bit in the check code itself, or cannot be repaired. For a repairable data error it gives the failing byte position (0..511) and bit position (0..7) inside the chunk.

A request carries both codes and a control bit. When that bit is set, an erased-looking stored code (every byte 0xFF) counts as a page that was never protected. The verdict is registered and appears one clock after the request is accepted. It is held until the next request. An optional streaming port lets the data bytes of the chunk pass through alongside their positions. The port flips the one faulty bit when the position matches a repairable error, so the corrected chunk comes out with no further buffering.

Top module: `nand_ecc_syndrome_fix`

## Requirements
- R1: When the stored and recomputed codes are equal, the verdict is clean (status 0). Status codes are: 0 clean, 1 data bit repaired, 2 error in check code only, 3 uncorrectable.
- R2: When ign_unset is 1 and the stored code is 0xFFFFFF, the verdict is clean whatever the recomputed code. When ign_unset is 0, the same codes are classified normally.
- R3: A syndrome in which every byte has bits 0/1, 2/3, 4/5 and 6/7 pairwise unequal is a repairable data error (status 1).
- R4: For status 1 the bit position is {s[23], s[21], s[19]}, with s[19] as the LSB, where s is the syndrome.
- R5: For status 1 the 9-bit byte position is, MSB first, s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1].
- R6: A syndrome with exactly one bit set gives status 2. In that case and in every status other than 1, both positions read 0.
- R7: Any other non-zero syndrome gives status 3.
- R8: The checks are evaluated in this priority: zero syndrome, then erased code, then repairable pattern, then single bit, then uncorrectable.
- R9: Code byte 0 sits in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16 of each 24-bit code port.
- R10: req_ready is 1. res_valid pulses for exactly one cycle, one clock after an accepted request. The verdict and positions hold their value until the next accepted request.
- R11: dat_out equals dat_in XOR (1 << bit position) only when the status is 1 and dat_idx equals the byte position. Otherwise dat_out equals dat_in.
- R12: After reset, res_valid is 0 and status and positions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_stored | input | 24 | Code read from the spare area |
| req_calc | input | 24 | Code recomputed over the chunk |
| req_ign_unset | input | 1 | Treat an all-0xFF stored code as clean |
| res_valid | output | 1 | One-cycle pulse: new verdict |
| res_status | output | 2 | Verdict code |
| res_byte_idx | output | 9 | Failing byte position |
| res_bit_idx | output | 3 | Failing bit position |
| dat_idx | input | 9 | Position of the streamed byte |
| dat_in | input | 8 | Streamed data byte |
| dat_out | output | 8 | Streamed byte after repair |

## Verification
The hardest situations to reach are the ones where the priority decides the verdict. Examples are an erased stored code whose syndrome also forms a valid repairable pattern or a single-bit pattern, and syndromes whose three bytes are laid out so that swapping the byte order would move the error somewhere else. The vector table builds each of these from chosen stored/recomputed pairs. Each pair is applied with the erased-code control both set and clear. Asymmetric syndromes (0x55AAAA and 0xAAAA55) give positions 0x0FF and 0x1F0, which exposes a byte-order or field-order mistake. Directed tests then stream bytes at, next to and away from the reported position after repairable and non-repairable verdicts.

// File: rtl/necc_pkg.sv
package necc_pkg;
   localparam int CODE_BYTES = 3;
   localparam int BYTE_W     = 8;
   localparam int CODE_W     = CODE_BYTES * BYTE_W;
   localparam int BYTE_IDX_W = 9;
   localparam int BIT_IDX_W  = 3;

   typedef enum logic [1:0] {
      ST_CLEAN    = 2'd0,
      ST_FIXED    = 2'd1,
      ST_CODE_ERR = 2'd2,
      ST_FATAL    = 2'd3
   } ecc_status_e;
endpackage

// File: rtl/necc_pair_check.sv
module necc_pair_check #(
   parameter int BW = 8
) (
   input  logic [BW-1:0] syn_byte,
   output logic          all_split
);
   localparam int PAIRS = BW / 2;

   logic [PAIRS-1:0] pair_ne;

   generate
      if ((BW % 2) != 0) begin : g_bad_width
         $error("necc_pair_check: BW must be even");
      end
      for (genvar k = 0; k < PAIRS; k++) begin : g_pair
         assign pair_ne[k] = syn_byte[2*k] ^ syn_byte[2*k+1];
      end
   endgenerate

   assign all_split = &pair_ne;
endmodule

// File: rtl/necc_loc_decode.sv
module necc_loc_decode
   import necc_pkg::*;
(
   input  logic [CODE_W-1:0]     syn,
   output logic [BYTE_IDX_W-1:0] byte_idx,
   output logic [BIT_IDX_W-1:0]  bit_idx
);
   // Odd bits of the syndrome carry the location; even bits are their complements.
   localparam int ODD_BITS = CODE_W / 2;

   logic [ODD_BITS-1:0] odd_bits;

   generate
      if (ODD_BITS != BYTE_IDX_W + BIT_IDX_W) begin : g_bad_split
         $error("necc_loc_decode: location widths do not fill the syndrome");
      end
      for (genvar i = 0; i < ODD_BITS; i++) begin : g_odd
         assign odd_bits[i] = syn[2*i+1];
      end
   endgenerate

   assign byte_idx = odd_bits[BYTE_IDX_W-1:0];
   assign bit_idx  = odd_bits[ODD_BITS-1:BYTE_IDX_W];
endmodule

// File: rtl/necc_byte_patch.sv
module necc_byte_patch
   import necc_pkg::*;
#(
   parameter bit HAS_PATCH = 1'b1
) (
   input  logic [1:0]            status,
   input  logic [BYTE_IDX_W-1:0] err_byte,
   input  logic [BIT_IDX_W-1:0]  err_bit,
   input  logic [BYTE_IDX_W-1:0] dat_idx,
   input  logic [BYTE_W-1:0]     dat_in,
   output logic [BYTE_W-1:0]     dat_out
);
   generate
      if (HAS_PATCH) begin : g_patch
         logic             hit;
         logic [BYTE_W-1:0] flip;
         always_comb begin
            hit  = (status == ST_FIXED) && (dat_idx == err_byte);
            flip = '0;
            if (hit) flip[err_bit] = 1'b1;
         end
         assign dat_out = dat_in ^ flip;
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = ^{status, err_byte, err_bit, dat_idx};
         assign dat_out   = dat_in;
      end
   endgenerate
endmodule

// File: rtl/nand_ecc_syndrome_fix.sv
module nand_ecc_syndrome_fix
   import necc_pkg::*;
#(
   parameter bit HAS_PATCH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [CODE_W-1:0]     req_stored,
   input  logic [CODE_W-1:0]     req_calc,
   input  logic                  req_ign_unset,
   output logic                  res_valid,
   output logic [1:0]            res_status,
   output logic [BYTE_IDX_W-1:0] res_byte_idx,
   output logic [BIT_IDX_W-1:0]  res_bit_idx,
   input  logic [BYTE_IDX_W-1:0] dat_idx,
   input  logic [BYTE_W-1:0]     dat_in,
   output logic [BYTE_W-1:0]     dat_out
);
   localparam logic [CODE_W-1:0] ERASED = {CODE_W{1'b1}};

   logic [CODE_W-1:0]     syn;
   logic [CODE_BYTES-1:0] byte_split;
   logic                  is_zero, is_erased, is_fixable, is_single;
   logic [BYTE_IDX_W-1:0] loc_byte;
   logic [BIT_IDX_W-1:0]  loc_bit;
   ecc_status_e           nxt_status;
   logic [BYTE_IDX_W-1:0] nxt_byte;
   logic [BIT_IDX_W-1:0]  nxt_bit;
   logic                  accept;

   assign req_ready = 1'b1;
   assign accept    = req_valid && req_ready;
   assign syn       = req_stored ^ req_calc;

   generate
      for (genvar b = 0; b < CODE_BYTES; b++) begin : g_byte
         necc_pair_check #(.BW(BYTE_W)) u_pair (
            .syn_byte  (syn[b*BYTE_W +: BYTE_W]),
            .all_split (byte_split[b])
         );
      end
   endgenerate

   necc_loc_decode u_loc (
      .syn      (syn),
      .byte_idx (loc_byte),
      .bit_idx  (loc_bit)
   );

   always_comb begin
      is_zero    = (syn == '0);
      is_erased  = req_ign_unset && (req_stored == ERASED);
      is_fixable = &byte_split;
      is_single  = $onehot(syn);
      nxt_byte   = '0;
      nxt_bit    = '0;
      if (is_zero || is_erased) begin
         nxt_status = ST_CLEAN;
      end else if (is_fixable) begin
         nxt_status = ST_FIXED;
         nxt_byte   = loc_byte;
         nxt_bit    = loc_bit;
      end else if (is_single) begin
         nxt_status = ST_CODE_ERR;
      end else begin
         nxt_status = ST_FATAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_status   <= ST_CLEAN;
         res_byte_idx <= '0;
         res_bit_idx  <= '0;
      end else begin
         res_valid <= accept;
         if (accept) begin
            res_status   <= nxt_status;
            res_byte_idx <= nxt_byte;
            res_bit_idx  <= nxt_bit;
         end
      end
   end

   necc_byte_patch #(.HAS_PATCH(HAS_PATCH)) u_patch (
      .status   (res_status),
      .err_byte (res_byte_idx),
      .err_bit  (res_bit_idx),
      .dat_idx  (dat_idx),
      .dat_in   (dat_in),
      .dat_out  (dat_out)
   );
endmodule

// File: rtl/necc_checker.sv
module necc_checker
   import necc_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [CODE_W-1:0]     req_stored,
   input logic [CODE_W-1:0]     req_calc,
   input logic                  res_valid,
   input logic [1:0]            res_status,
   input logic [BYTE_IDX_W-1:0] res_byte_idx,
   input logic [BIT_IDX_W-1:0]  res_bit_idx,
   input logic [BYTE_W-1:0]     dat_in,
   input logic [BYTE_W-1:0]     dat_out
);
   p_clean_on_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_stored == req_calc) |=> (res_status == 2'd0));

   p_loc_zero_unless_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_status != 2'd1) |-> (res_byte_idx == '0 && res_bit_idx == '0));

   p_pulse_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> res_valid);

   p_no_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(res_status) && $stable(res_byte_idx) && $stable(res_bit_idx)));

   p_pass_unless_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_status != 2'd1) |-> (dat_out == dat_in));

   p_flip_at_most_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dat_out ^ dat_in) <= 1);
endmodule

bind nand_ecc_syndrome_fix necc_checker u_necc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_stored   (req_stored),
   .req_calc     (req_calc),
   .res_valid    (res_valid),
   .res_status   (res_status),
   .res_byte_idx (res_byte_idx),
   .res_bit_idx  (res_bit_idx),
   .dat_in       (dat_in),
   .dat_out      (dat_out)
);

// File: tb/nand_ecc_syndrome_fix_test.sv
`timescale 1ns/1ps
module nand_ecc_syndrome_fix_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_stored = '0;
   logic [23:0] req_calc = '0;
   logic        req_ign_unset = 1'b0;
   logic        res_valid;
   logic [1:0]  res_status;
   logic [8:0]  res_byte_idx;
   logic [2:0]  res_bit_idx;
   logic [8:0]  dat_idx = '0;
   logic [7:0]  dat_in = '0;
   logic [7:0]  dat_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nand_ecc_syndrome_fix uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_stored(req_stored), .req_calc(req_calc), .req_ign_unset(req_ign_unset),
      .res_valid(res_valid), .res_status(res_status), .res_byte_idx(res_byte_idx),
      .res_bit_idx(res_bit_idx), .dat_idx(dat_idx), .dat_in(dat_in), .dat_out(dat_out)
   );

   typedef struct packed {
      logic [23:0] stored;
      logic [23:0] calc;
      logic        ign;
      logic [1:0]  st;
      logic [8:0]  byt;
      logic [2:0]  bt;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{24'h123456, 24'h123456, 1'b0, 2'd0, 9'h000, 3'd0},  // R1
      '{24'hFFFFFF, 24'hFFFFFF, 1'b1, 2'd0, 9'h000, 3'd0},  // R1 R8
      '{24'hFFFFFF, 24'h123456, 1'b1, 2'd0, 9'h000, 3'd0},  // R2
      '{24'hFFFFFF, 24'h123456, 1'b0, 2'd3, 9'h000, 3'd0},  // R2 R7
      '{24'h555555, 24'h000000, 1'b0, 2'd1, 9'h000, 3'd0},  // R3
      '{24'hAAAAAA, 24'h000000, 1'b0, 2'd1, 9'h1FF, 3'd7},  // R4 R5
      '{24'h123456, 24'h8BAD30, 1'b0, 2'd1, 9'h0A5, 3'd5},  // R4 R5
      '{24'h55AAAA, 24'h000000, 1'b0, 2'd1, 9'h0FF, 3'd0},  // R9
      '{24'hAAAA55, 24'h000000, 1'b0, 2'd1, 9'h1F0, 3'd7},  // R9
      '{24'hFFFFFF, 24'hAAAAAA, 1'b1, 2'd0, 9'h000, 3'd0},  // R8
      '{24'hFFFFFF, 24'hAAAAAA, 1'b0, 2'd1, 9'h000, 3'd0},  // R8
      '{24'hFFFFFF, 24'hFFFFFE, 1'b1, 2'd0, 9'h000, 3'd0},  // R8
      '{24'hFFFFFF, 24'hFFFFFE, 1'b0, 2'd2, 9'h000, 3'd0},  // R6 R8
      '{24'h000100, 24'h000000, 1'b0, 2'd2, 9'h000, 3'd0},  // R6
      '{24'h800000, 24'h000000, 1'b0, 2'd2, 9'h000, 3'd0},  // R6
      '{24'h000001, 24'h000000, 1'b0, 2'd2, 9'h000, 3'd0},  // R6
      '{24'h000003, 24'h000000, 1'b0, 2'd3, 9'h000, 3'd0},  // R7
      '{24'h0000FF, 24'h000000, 1'b0, 2'd3, 9'h000, 3'd0}   // R7
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [23:0] s, input logic [23:0] c, input logic ig);
      @(negedge clk);
      req_valid = 1'b1; req_stored = s; req_calc = c; req_ign_unset = ig;
      @(negedge clk);
      req_valid = 1'b0; req_stored = '0; req_calc = '0; req_ign_unset = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R12 res_valid", res_valid, 0);
      chk("R12 status", res_status, 0);
      chk("R12 location", {res_byte_idx, res_bit_idx}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready", req_ready, 1);

      for (int i = 0; i < NV; i++) begin
         send(VECS[i].stored, VECS[i].calc, VECS[i].ign);
         chk("R10 valid pulse", res_valid, 1);
         chk("R1-R9 status", res_status, VECS[i].st);
         chk("R5 byte index", res_byte_idx, VECS[i].byt);
         chk("R4 bit index", res_bit_idx, VECS[i].bt);
      end

      // R10: pulse lasts one cycle and the verdict holds
      send(24'h123456, 24'h8BAD30, 1'b0);
      @(negedge clk);
      chk("R10 pulse ends", res_valid, 0);
      chk("R10 status held", res_status, 1);
      chk("R10 byte held", res_byte_idx, 9'h0A5);

      // R11: patch at matching position only
      dat_idx = 9'h0A5; dat_in = 8'h00; #1;
      chk("R11 flip at hit", dat_out, 8'h20);
      dat_in = 8'hFF; #1;
      chk("R11 flip high byte", dat_out, 8'hDF);
      dat_idx = 9'h0A4; #1;
      chk("R11 neighbour untouched", dat_out, 8'hFF);
      dat_idx = 9'h1A5; #1;
      chk("R11 upper bit differs", dat_out, 8'hFF);

      // R11: no patch after code-only error
      send(24'h000100, 24'h000000, 1'b0);
      dat_idx = 9'h000; dat_in = 8'h3C; #1;
      chk("R11 no flip status2", dat_out, 8'h3C);
      chk("R6 location zero", {res_byte_idx, res_bit_idx}, 0);

      // R11: no patch after erased-code clean verdict with repairable syndrome
      send(24'hFFFFFF, 24'hAAAAAA, 1'b1);
      dat_idx = 9'h000; dat_in = 8'h00; #1;
      chk("R11 no flip when clean", dat_out, 8'h00);

      // R11: patch at byte 0 bit 0
      send(24'h555555, 24'h000000, 1'b0);
      #1;
      chk("R11 flip byte0 bit0", dat_out, 8'h01);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule